// File: doc/BRIEF.md
# Unpacked and Packed Decimal Adjust Unit

This unit performs the six decimal-correction steps that follow or precede binary arithmetic on decimal data. It operates on an 8-bit low accumulator byte and an 8-bit high accumulator byte. Four of the steps work on unpacked digits, one digit per byte. Two of them fix up an add or a subtract, and two prepare for or finish a multiply or a divide. The remaining two steps correct a byte that holds two packed decimal digits after an add or a subtract. A caller presents the two bytes, the incoming carry and auxiliary flags and a 3-bit operation code, and pulses `start_i` for one cycle. The unit then returns both bytes, a five-bit flag vector and a one-cycle `done_o`.

The four add and subtract corrections finish in a single cycle. The step that splits a byte into quotient and remainder by ten uses restoring division, one quotient bit per cycle. The step that folds the high digit into the low byte multiplies by ten with shift-and-add, one multiplier bit per cycle. `busy_o` is high while one of these iterative steps is running, and a start request that arrives during that time is dropped. Results and flags stay on the outputs until the next completed operation.

Top module: `dec_adjust_unit`

## Requirements
- R1: Opcode 0 (unpacked add correction): if the low nibble of `lo_i` exceeds 9 or `af_i` is 1, the low byte gets +6 and the high byte gets +1 (mod 256), and carry and auxiliary are set to 1; otherwise both are 0 and the bytes are unchanged. In both cases the low byte is then masked to its low nibble.
- R2: Opcode 1 (unpacked subtract correction) follows the same test as R1, but subtracts 6 from the low byte and 1 from the high byte (mod 256). Carry and auxiliary are set exactly as in R1, and the low byte is then masked to its low nibble.
- R3: After opcodes 0 and 1, bits 7..4 of `lo_o` are always zero.
- R4: Opcode 3 (prepare for divide) gives `lo_o` = (10 × `hi_i` + `lo_i`) mod 256 and `hi_o` = 0. Carry and auxiliary are 0.
- R5: Opcode 2 (finish multiply) gives `hi_o` = `lo_i` / 10 and `lo_o` = `lo_i` mod 10, both unsigned. Carry and auxiliary are 0, and `cf_i` and `af_i` have no effect.
- R6: Opcode 4 (packed add correction): if the low nibble exceeds 9 or `af_i` is 1, the step adds 6 and sets auxiliary. Then, if the original `lo_i` exceeds 0x99 or `cf_i` is 1, it adds 0x60 and sets carry. Each flag is 0 when its step is skipped, and `hi_o` equals `hi_i`.
- R7: Opcode 5 (packed subtract correction) uses the same conditions and flags as R6, but subtracts 6 and subtracts 0x60. `hi_o` equals `hi_i`.
- R8: The `flags_o` bit positions are 0 carry, 1 auxiliary, 2 parity, 3 sign and 4 zero. For every operation, parity is 1 when `lo_o` has an even number of ones, sign is `lo_o[7]`, and zero is 1 when `lo_o` is 0.
- R9: Count the rising edge that samples an accepted `start_i` as edge 1. `done_o` is high in the cycle after edge 1 for opcodes 0, 1, 4 and 5, after edge 9 for opcode 2, and after edge 5 for opcode 3. The results are valid in that same cycle, and `busy_o` is low in it.
- R10: `done_o` is high for exactly one cycle per accepted operation. `lo_o`, `hi_o` and `flags_o` change only in a cycle in which `done_o` is high.
- R11: While `busy_o` is high, `start_i` is ignored. The running operation completes with its own result, and it gives only one `done_o` pulse.
- R12: A start request carrying opcode 6 or 7 is ignored: no `done_o`, no change of any output.
- R13: While `rst_n` is low, `lo_o`, `hi_o`, `flags_o`, `done_o` and `busy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to run `op_i` on the presented operands |
| op_i | input | 3 | Operation code (0..5 valid, 6 and 7 ignored) |
| lo_i | input | 8 | Low accumulator byte |
| hi_i | input | 8 | High accumulator byte |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary flag |
| lo_o | output | 8 | Resulting low byte |
| hi_o | output | 8 | Resulting high byte |
| flags_o | output | 5 | Flags: [0] carry, [1] aux, [2] parity, [3] sign, [4] zero |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Iterative operation in progress |

## Verification
The four correction opcodes answer after the edge that samples the request. The divide-by-ten step answers eight edges later, after edge 9, and the multiply-by-ten step four edges later, after edge 5. The bench drives each request at a falling edge and then samples one time unit after each rising edge. It records the edge number of the first `done_o` and compares that number with the count given in R9. Results are captured in that cycle only. The bench then keeps sampling to edge 12, which confirms that the pulse is single and that the outputs hold. The same window, with no pulse at all, is used to confirm that a dropped request (busy or reserved opcode) leaves the outputs untouched.

// File: rtl/dau_pkg.sv
package dau_pkg;

  localparam int BYTE_W = 8;
  localparam int FLAG_W = 5;

  // flag vector bit positions
  localparam int FL_C = 0;
  localparam int FL_A = 1;
  localparam int FL_P = 2;
  localparam int FL_S = 3;
  localparam int FL_Z = 4;

  typedef enum logic [2:0] {
    OP_UADD = 3'd0,
    OP_USUB = 3'd1,
    OP_UMUL = 3'd2,
    OP_UDIV = 3'd3,
    OP_PADD = 3'd4,
    OP_PSUB = 3'd5
  } dau_op_e;

  function automatic logic [FLAG_W-1:0] pack_flags(
    input logic [BYTE_W-1:0] v,
    input logic              c,
    input logic              a
  );
    logic [FLAG_W-1:0] f;
    f        = '0;
    f[FL_C]  = c;
    f[FL_A]  = a;
    f[FL_P]  = ~^v;
    f[FL_S]  = v[BYTE_W-1];
    f[FL_Z]  = (v == '0);
    return f;
  endfunction

endpackage

// File: rtl/dau_rst_sync.sv
module dau_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/dau_bcd_fix.sv
module dau_bcd_fix
  import dau_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  logic [2:0]        op_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              cf_o,
  output logic              af_o
);

  localparam logic [3:0]        DIG_MAX   = 4'(RADIX - 1);
  localparam logic [BYTE_W-1:0] LOW_STEP  = BYTE_W'(16 - RADIX);
  localparam logic [BYTE_W-1:0] HIGH_STEP = BYTE_W'((16 - RADIX) * 16);
  localparam logic [BYTE_W-1:0] PACK_MAX  = BYTE_W'((RADIX - 1) * 17);

  logic              low_fix;
  logic              high_fix;
  logic [BYTE_W-1:0] lo_stage;

  always_comb begin
    low_fix  = (lo_i[3:0] > DIG_MAX) || af_i;
    high_fix = (lo_i > PACK_MAX) || cf_i;
    lo_stage = lo_i;
    lo_o     = lo_i;
    hi_o     = hi_i;
    cf_o     = 1'b0;
    af_o     = 1'b0;
    case (dau_op_e'(op_i))
      OP_UADD: begin
        if (low_fix) begin
          lo_stage = lo_i + LOW_STEP;
          hi_o     = hi_i + 8'd1;
          cf_o     = 1'b1;
          af_o     = 1'b1;
        end
        lo_o = {4'h0, lo_stage[3:0]};
      end
      OP_USUB: begin
        if (low_fix) begin
          lo_stage = lo_i - LOW_STEP;
          hi_o     = hi_i - 8'd1;
          cf_o     = 1'b1;
          af_o     = 1'b1;
        end
        lo_o = {4'h0, lo_stage[3:0]};
      end
      OP_PADD: begin
        if (low_fix) begin
          lo_stage = lo_i + LOW_STEP;
          af_o     = 1'b1;
        end
        if (high_fix) begin
          lo_o = lo_stage + HIGH_STEP;
          cf_o = 1'b1;
        end else begin
          lo_o = lo_stage;
        end
      end
      OP_PSUB: begin
        if (low_fix) begin
          lo_stage = lo_i - LOW_STEP;
          af_o     = 1'b1;
        end
        if (high_fix) begin
          lo_o = lo_stage - HIGH_STEP;
          cf_o = 1'b1;
        end else begin
          lo_o = lo_stage;
        end
      end
      default: begin
        lo_o = lo_i;
      end
    endcase
  end

endmodule

// File: rtl/dau_div_iter.sv
module dau_div_iter #(
  parameter int W       = 8,
  parameter int DIVISOR = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  output logic         last_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);

  localparam int REM_W = $clog2(DIVISOR) + 1;
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [REM_W-1:0] DIV_V  = REM_W'(DIVISOR);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(W - 1);

  logic             run_q,  run_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic [W-1:0]     quot_q, quot_d;
  logic [REM_W-2:0] rem_q,  rem_d;
  logic [REM_W-1:0] trial;
  logic [REM_W-1:0] trial_sub;
  logic             fits;
  logic [W-1:0]     quot_nx;
  logic [REM_W-2:0] rem_nx;

  // one restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    trial     = {rem_q, quot_q[W-1]};
    fits      = (trial >= DIV_V);
    trial_sub = trial - DIV_V;
    rem_nx    = fits ? trial_sub[REM_W-2:0] : trial[REM_W-2:0];
    quot_nx   = {quot_q[W-2:0], fits};
  end

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    quot_d = quot_q;
    rem_d  = rem_q;
    if (load_i) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      quot_d = dividend_i;
      rem_d  = '0;
    end else if (run_q) begin
      cnt_d  = cnt_q + 1'b1;
      quot_d = quot_nx;
      rem_d  = rem_nx;
      if (cnt_q == CNT_END) begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      quot_q <= '0;
      rem_q  <= '0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      quot_q <= quot_d;
      rem_q  <= rem_d;
    end
  end

  assign last_o = run_q && (cnt_q == CNT_END);
  assign quot_o = quot_nx;
  assign rem_o  = {{(W - REM_W + 1){1'b0}}, rem_nx};

endmodule

// File: rtl/dau_mul_iter.sv
module dau_mul_iter #(
  parameter int W      = 8,
  parameter int FACTOR = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] addend_i,
  output logic         last_o,
  output logic [W-1:0] prod_o
);

  localparam int STEPS = $clog2(FACTOR + 1);
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [STEPS-1:0] FBITS   = STEPS'(FACTOR);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STEPS - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     acc_q, acc_d;
  logic [W-1:0]     mc_q,  mc_d;
  logic [W-1:0]     acc_nx;

  // one shift-and-add step per factor bit, LSB first
  always_comb begin
    acc_nx = FBITS[cnt_q] ? (acc_q + mc_q) : acc_q;
  end

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    acc_d = acc_q;
    mc_d  = mc_q;
    if (load_i) begin
      run_d = 1'b1;
      cnt_d = '0;
      acc_d = addend_i;
      mc_d  = mcand_i;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = acc_nx;
      mc_d  = {mc_q[W-2:0], 1'b0};
      if (cnt_q == CNT_END) begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
      mc_q  <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      mc_q  <= mc_d;
    end
  end

  assign last_o = run_q && (cnt_q == CNT_END);
  assign prod_o = acc_nx;

endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
  import dau_pkg::*;
#(
  parameter int RADIX       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              done_o,
  output logic              busy_o
);

  logic              rst_n_s;

  logic              op_ok;
  logic              accept;
  logic              div_go, mul_go, fix_go;

  logic [BYTE_W-1:0] fix_lo, fix_hi;
  logic              fix_cf, fix_af;
  logic              div_last, mul_last;
  logic [BYTE_W-1:0] div_q, div_r, mul_p;

  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [FLAG_W-1:0] fl_q, fl_d;
  logic              done_q, done_d;
  logic              busy_q, busy_d;

  dau_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // request qualification
  always_comb begin
    op_ok  = (op_i <= OP_PSUB);
    accept = start_i && !busy_q && op_ok;
    div_go = accept && (op_i == OP_UMUL);
    mul_go = accept && (op_i == OP_UDIV);
    fix_go = accept && !div_go && !mul_go;
  end

  dau_bcd_fix #(.RADIX(RADIX)) u_fix (
    .op_i (op_i),
    .lo_i (lo_i),
    .hi_i (hi_i),
    .cf_i (cf_i),
    .af_i (af_i),
    .lo_o (fix_lo),
    .hi_o (fix_hi),
    .cf_o (fix_cf),
    .af_o (fix_af)
  );

  dau_div_iter #(.W(BYTE_W), .DIVISOR(RADIX)) u_div (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (div_go),
    .dividend_i (lo_i),
    .last_o     (div_last),
    .quot_o     (div_q),
    .rem_o      (div_r)
  );

  dau_mul_iter #(.W(BYTE_W), .FACTOR(RADIX)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (mul_go),
    .mcand_i  (hi_i),
    .addend_i (lo_i),
    .last_o   (mul_last),
    .prod_o   (mul_p)
  );

  // result selection and control next state
  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    fl_d   = fl_q;
    done_d = 1'b0;
    busy_d = busy_q;
    if (fix_go) begin
      lo_d   = fix_lo;
      hi_d   = fix_hi;
      fl_d   = pack_flags(fix_lo, fix_cf, fix_af);
      done_d = 1'b1;
    end else if (div_last) begin
      lo_d   = div_r;
      hi_d   = div_q;
      fl_d   = pack_flags(div_r, 1'b0, 1'b0);
      done_d = 1'b1;
      busy_d = 1'b0;
    end else if (mul_last) begin
      lo_d   = mul_p;
      hi_d   = '0;
      fl_d   = pack_flags(mul_p, 1'b0, 1'b0);
      done_d = 1'b1;
      busy_d = 1'b0;
    end
    if (div_go || mul_go) begin
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lo_q   <= '0;
      hi_q   <= '0;
      fl_q   <= '0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      done_q <= done_d;
      busy_q <= busy_d;
      if (done_d) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
        fl_q <= fl_d;
      end
    end
  end

  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign flags_o = fl_q;
  assign done_o  = done_q;
  assign busy_o  = busy_q;

endmodule

// File: rtl/dau_chk.sv
module dau_chk
  import dau_pkg::*;
#(
  parameter int RADIX = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [2:0]        op_i,
  input logic [BYTE_W-1:0] lo_o,
  input logic [BYTE_W-1:0] hi_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              done_o,
  input logic              busy_o
);

  logic [2:0] last_op_q;

  // remember the opcode of the most recently accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op_q <= 3'd7;
    end else if (start_i && !busy_o && (op_i <= OP_PSUB)) begin
      last_op_q <= op_i;
    end
  end

  AST_ASCII_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ((last_op_q == OP_UADD) || (last_op_q == OP_USUB)) |-> (lo_o[7:4] == 4'h0)); // R3

  AST_DIVPREP_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (last_op_q == OP_UDIV) |-> (hi_o == '0)); // R4

  AST_MULFIN_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (last_op_q == OP_UMUL) |-> (lo_o < BYTE_W'(RADIX))); // R5

  AST_FLAG_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flags_o[FL_P] == ~^lo_o)); // R8

  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flags_o[FL_Z] == (lo_o == '0))); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(lo_o) && $stable(hi_o) && $stable(flags_o))); // R10

endmodule

bind dec_adjust_unit dau_chk #(.RADIX(RADIX)) u_dau_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .op_i    (op_i),
  .lo_o    (lo_o),
  .hi_o    (hi_o),
  .flags_o (flags_o),
  .done_o  (done_o),
  .busy_o  (busy_o)
);

// File: tb/dec_adjust_unit_tb_top.sv
`timescale 1ns/1ps
module dec_adjust_unit_tb_top;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [2:0] op_i;
  logic [7:0] lo_i, hi_i;
  logic       cf_i, af_i;
  logic [7:0] lo_o, hi_o;
  logic [4:0] flags_o;
  logic       done_o, busy_o;

  int n_chk;
  int n_bad;

  dec_adjust_unit dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .lo_i    (lo_i),
    .hi_i    (hi_i),
    .cf_i    (cf_i),
    .af_i    (af_i),
    .lo_o    (lo_o),
    .hi_o    (hi_o),
    .flags_o (flags_o),
    .done_o  (done_o),
    .busy_o  (busy_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {op, hi, lo, cf, af, exp_hi, exp_lo, exp_flags}; flags [0]C [1]A [2]P [3]S [4]Z
  localparam logic [41:0] VEC [22] = '{
    {3'd0, 8'h00, 8'h0B, 1'b0, 1'b0, 8'h01, 8'h01, 5'h03},
    {3'd0, 8'h05, 8'h34, 1'b0, 1'b0, 8'h05, 8'h04, 5'h00},
    {3'd0, 8'h02, 8'h03, 1'b0, 1'b1, 8'h03, 8'h09, 5'h07},
    {3'd0, 8'hFF, 8'h0A, 1'b0, 1'b0, 8'h00, 8'h00, 5'h17},
    {3'd1, 8'h03, 8'h0F, 1'b0, 1'b0, 8'h02, 8'h09, 5'h07},
    {3'd1, 8'h00, 8'h02, 1'b0, 1'b1, 8'hFF, 8'h0C, 5'h07},
    {3'd1, 8'h04, 8'h38, 1'b0, 1'b0, 8'h04, 8'h08, 5'h00},
    {3'd2, 8'h12, 8'h4F, 1'b0, 1'b0, 8'h07, 8'h09, 5'h04},
    {3'd2, 8'h00, 8'hFF, 1'b1, 1'b1, 8'h19, 8'h05, 5'h04},
    {3'd2, 8'h33, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 5'h14},
    {3'd3, 8'h07, 8'h09, 1'b0, 1'b0, 8'h00, 8'h4F, 5'h00},
    {3'd3, 8'h09, 8'h09, 1'b1, 1'b1, 8'h00, 8'h63, 5'h04},
    {3'd3, 8'h19, 8'h0A, 1'b0, 1'b0, 8'h00, 8'h04, 5'h00},
    {3'd3, 8'h0D, 8'h00, 1'b0, 1'b0, 8'h00, 8'h82, 5'h0C},
    {3'd3, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 5'h14},
    {3'd4, 8'h55, 8'hAE, 1'b0, 1'b0, 8'h55, 8'h14, 5'h07},
    {3'd4, 8'h11, 8'h45, 1'b0, 1'b0, 8'h11, 8'h45, 5'h00},
    {3'd4, 8'hA0, 8'h12, 1'b1, 1'b1, 8'hA0, 8'h78, 5'h07},
    {3'd4, 8'h00, 8'h9A, 1'b0, 1'b0, 8'h00, 8'h00, 5'h17},
    {3'd5, 8'h00, 8'hFA, 1'b0, 1'b0, 8'h00, 8'h94, 5'h0B},
    {3'd5, 8'h3C, 8'h28, 1'b0, 1'b1, 8'h3C, 8'h22, 5'h06},
    {3'd5, 8'h00, 8'h05, 1'b1, 1'b0, 8'h00, 8'hA5, 5'h0D}
  };

  function automatic int lat_of(input logic [2:0] op);
    if (op == 3'd2) return 9;
    if (op == 3'd3) return 5;
    return 1;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R5";
      3'd3:    return "R4";
      3'd4:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // issue one request and watch 12 edges; capture the first done cycle
  task automatic run_op(input logic [2:0] op, input logic [7:0] hi, input logic [7:0] lo,
                        input logic cf, input logic af,
                        output int lat, output int pulses,
                        output logic [7:0] r_hi, output logic [7:0] r_lo, output logic [4:0] r_fl);
    @(negedge clk);
    op_i = op; hi_i = hi; lo_i = lo; cf_i = cf; af_i = af; start_i = 1'b1;
    lat = 0; pulses = 0; r_hi = hi_o; r_lo = lo_o; r_fl = flags_o;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); #1;
      if (k == 1) start_i = 1'b0;
      if (done_o) begin
        pulses++;
        if (lat == 0) begin
          lat = k; r_hi = hi_o; r_lo = lo_o; r_fl = flags_o;
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat, pulses;
    logic [7:0] r_hi, r_lo;
    logic [4:0] r_fl;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; lo_i = '0; hi_i = '0; cf_i = 1'b0; af_i = 1'b0;
    #12;
    // R13 reset state
    check("R13", "lo_o", 32'(lo_o), 32'h0);
    check("R13", "hi_o", 32'(hi_o), 32'h0);
    check("R13", "flags_o", 32'(flags_o), 32'h0);
    check("R13", "done_o", 32'(done_o), 32'h0);
    check("R13", "busy_o", 32'(busy_o), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: results, flags, latency, single pulse, hold
    for (int i = 0; i < 22; i++) begin
      logic [41:0] v;
      v = VEC[i];
      run_op(v[41:39], v[38:31], v[30:23], v[22], v[21], lat, pulses, r_hi, r_lo, r_fl);
      check(tag_of(v[41:39]), $sformatf("vec%0d hi", i), 32'(r_hi), 32'(v[20:13]));
      check(tag_of(v[41:39]), $sformatf("vec%0d lo", i), 32'(r_lo), 32'(v[12:5]));
      check("R8", $sformatf("vec%0d flags", i), 32'(r_fl), 32'(v[4:0]));
      check("R9", $sformatf("vec%0d latency", i), 32'(lat), 32'(lat_of(v[41:39])));
      check("R10", $sformatf("vec%0d pulses", i), 32'(pulses), 32'd1);
      check("R10", $sformatf("vec%0d hold", i), 32'({hi_o, lo_o, flags_o}), 32'({r_hi, r_lo, r_fl}));
      if (v[41:39] <= 3'd1) begin
        check("R3", $sformatf("vec%0d high nibble", i), 32'(r_lo[7:4]), 32'h0);
      end
    end

    // R11: a new request during a divide-by-ten run is dropped
    begin
      int b_lat, b_pulses;
      logic busy_seen;
      logic [7:0] b_hi, b_lo;
      logic [4:0] b_fl;
      @(negedge clk);
      op_i = 3'd2; hi_i = 8'h00; lo_i = 8'h4F; cf_i = 1'b0; af_i = 1'b0; start_i = 1'b1;
      b_lat = 0; b_pulses = 0; busy_seen = 1'b0; b_hi = '0; b_lo = '0; b_fl = '0;
      for (int k = 1; k <= 12; k++) begin
        @(posedge clk); #1;
        if (k == 1) begin
          busy_seen = busy_o;
          op_i = 3'd0; lo_i = 8'h0B; hi_i = 8'h40;
        end
        if (k == 3) start_i = 1'b0;
        if (done_o) begin
          b_pulses++;
          if (b_lat == 0) begin
            b_lat = k; b_hi = hi_o; b_lo = lo_o; b_fl = flags_o;
          end
        end
      end
      check("R11", "busy after accept", 32'(busy_seen), 32'h1);
      check("R11", "done pulses", 32'(b_pulses), 32'd1);
      check("R11", "latency", 32'(b_lat), 32'd9);
      check("R11", "hi", 32'(b_hi), 32'h07);
      check("R11", "lo", 32'(b_lo), 32'h09);
      check("R11", "flags", 32'(b_fl), 32'h04);
    end

    // R12: reserved opcodes leave everything unchanged (outputs now 07/09/04)
    for (int c = 6; c <= 7; c++) begin
      run_op(3'(c), 8'h22, 8'h0F, 1'b1, 1'b1, lat, pulses, r_hi, r_lo, r_fl);
      check("R12", $sformatf("op%0d pulses", c), 32'(pulses), 32'd0);
      check("R12", $sformatf("op%0d outputs", c), 32'({hi_o, lo_o, flags_o}), 32'({8'h07, 8'h09, 5'h04}));
      check("R12", $sformatf("op%0d busy", c), 32'(busy_o), 32'h0);
    end

    // R9: multiply step immediately followed by a single-cycle step
    run_op(3'd3, 8'h02, 8'h03, 1'b0, 1'b0, lat, pulses, r_hi, r_lo, r_fl);
    check("R9", "mul latency", 32'(lat), 32'd5);
    check("R4", "23 result", 32'({r_hi, r_lo}), 32'h0017);
    run_op(3'd5, 8'h01, 8'h9A, 1'b0, 1'b0, lat, pulses, r_hi, r_lo, r_fl);
    check("R9", "psub latency", 32'(lat), 32'd1);
    check("R7", "9A result", 32'({r_hi, r_lo}), 32'h0134);
    check("R8", "9A flags", 32'(r_fl), 32'h03);

    // R13: reset in the middle of a run clears everything
    @(negedge clk);
    op_i = 3'd2; lo_i = 8'hC8; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R13", "mid-run outputs", 32'({hi_o, lo_o, flags_o, done_o, busy_o}), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R13", "after release", 32'({hi_o, lo_o, flags_o, done_o, busy_o}), 32'h0);

    finish_run();
  end

endmodule